// File: doc/BRIEF.md
# Resistive Touch Conversion Sequencer

This block schedules the measurements of a four-wire resistive touch panel and of two auxiliary analog inputs around an external successive-approximation converter. A state-cycle timebase splits every frame into fixed windows. The block samples the pen comparator, drives the X plate and then the Y plate for a programmable settling time, and starts a conversion at the end of each drive window. On request it also converts one auxiliary input later in the same frame. The converter is seen only through a start pulse, a channel code, a done strobe and a 10-bit result.

Each of the four channels keeps its latest result and a four-deep history. A mode input selects either the raw value or the rolling mean. A host reads any channel one byte at a time over an 8-bit bus that floats while it is not enabled. A low pulse marks each fresh coordinate pair or auxiliary result. When no pen has been seen for a programmable number of frames the block stops its timebase and waits. A pen touch or an auxiliary request wakes it, and a hold-down input also stops it.

Top module: `touch_seq`

## Requirements
- R1: One state cycle lasts CLKS_PER_STATE clocks (16 by default) and one frame lasts FRAME_STATES state cycles (230 by default), so successive X drive starts are 3680 clocks apart.
- R2: The plate drive stays on for 5, 7, 10 or 13 state cycles for `speed` codes 0, 1, 2 and 3, after which `adc_start` pulses for one clock.
- R3: Within a frame the pen comparator is sampled first, then the X plate is driven (from state cycle 30), then the Y plate (from state cycle 80), and never both at once.
- R4: An `aux_request` pulse seen before state cycle 115 is converted in the same frame, and one seen later is converted in the following frame. `aux_pick` = 0 selects auxiliary channel 0 and 1 selects channel 1. This works with no pen present.
- R5: `no_touch` follows the inverse of `pen_touch` as sampled in the pen-detect window. While it is 1, no plate is driven and the X and Y results keep their values.
- R6: `fresh_n` is low for exactly one clock when a Y result or an auxiliary result is stored, and does not pulse for X alone.
- R7: With `smooth` = 0 a channel reads its latest sample. With `smooth` = 1 it reads the sum of its last four samples shifted right by two, with the history zeroed at reset.
- R8: `{grp_sel,item_sel}` selects the channel: 00 aux 0, 01 aux 1, 10 X, 11 Y. `dbus` is driven only while `bus_en_n` is 0 and is high-impedance otherwise.
- R9: With `upper_byte` = 1 `dbus` carries result bits 9..2. With `upper_byte` = 0 it carries bits 1..0 in positions 7:6 and zeros in 5:0.
- R10: While `sleep_req` is 1, `asleep` is 1 and no plate drive or conversion start occurs. After release a fresh frame begins.
- R11: After IDLE_FRAMES consecutive frames that end with `no_touch` = 1, `asleep` rises and conversions stop. A `pen_touch` or `aux_request` clears it in the next clock.
- R12: After reset `no_touch` = 1, `fresh_n` = 1, both drives and `adc_start` are 0, and every channel reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| pen_touch | input | 1 | Pen comparator, 1 when the plates touch |
| speed | input | 2 | Drive on-time code |
| aux_request | input | 1 | Request one auxiliary conversion |
| aux_pick | input | 1 | Auxiliary channel choice for the request |
| smooth | input | 1 | 1 selects the four-sample rolling mean |
| sleep_req | input | 1 | Hold-down / power-down request |
| grp_sel | input | 1 | Output group select (aux or panel) |
| item_sel | input | 1 | Output item select within the group |
| upper_byte | input | 1 | 1 selects result bits 9..2 |
| bus_en_n | input | 1 | Active-low bus output enable |
| adc_done | input | 1 | Converter result valid strobe |
| adc_data | input | 10 | Converter result |
| drv_x | output | 1 | X plate drive enable |
| drv_y | output | 1 | Y plate drive enable |
| adc_start | output | 1 | One-clock conversion start |
| adc_ch | output | 2 | Channel being converted (aux0, aux1, X, Y) |
| no_touch | output | 1 | 1 when no pen was detected this frame |
| fresh_n | output | 1 | Active-low new-result pulse |
| asleep | output | 1 | Analog section powered down |
| dbus | output | 8 | Tri-state result byte |

## Verification
The auxiliary request path and the no-pen idle counter share the same frames. The bench issues auxiliary requests during frames with no pen, one before the T0 point and one after it. It checks that each result reaches its channel in the frame the request timing calls for, while the idle count keeps advancing. It then checks that the drop into power-down still lands at the end of the computed frame. A wake-up request that arrives while the block is asleep must both clear `asleep` on the next clock and leave its auxiliary conversion pending. The bench confirms this by reading the converted value back after the restarted frame.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  typedef enum logic [1:0] {
    CH_A0 = 2'd0,
    CH_A1 = 2'd1,
    CH_X  = 2'd2,
    CH_Y  = 2'd3
  } ch_e;

  // settling window length in state cycles per speed code
  function automatic logic [3:0] on_states(input logic [1:0] code);
    case (code)
      2'd0:    on_states = 4'd5;
      2'd1:    on_states = 4'd7;
      2'd2:    on_states = 4'd10;
      default: on_states = 4'd13;
    endcase
  endfunction

endpackage

// File: rtl/tsq_timebase.sv
module tsq_timebase #(
  parameter int CLKS_PER_STATE = 16,
  parameter int FRAME_STATES   = 230
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            run,
  output logic [$clog2(FRAME_STATES)-1:0] st_idx,
  output logic                            tick,
  output logic                            frame_end
);
  localparam int CW = $clog2(CLKS_PER_STATE);
  localparam int SW = $clog2(FRAME_STATES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      st_idx <= '0;
    end else if (cnt == CW'(CLKS_PER_STATE - 1)) begin
      cnt    <= '0;
      st_idx <= (st_idx == SW'(FRAME_STATES - 1)) ? '0 : st_idx + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick      = run && (cnt == '0);
  assign frame_end = run && (cnt == CW'(CLKS_PER_STATE - 1)) &&
                     (st_idx == SW'(FRAME_STATES - 1));

  // R1: a frame boundary restarts the state index
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (st_idx == '0));

endmodule

// File: rtl/tsq_chan_avg.sv
module tsq_chan_avg #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic         smooth,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  localparam int SH   = $clog2(DEPTH);
  localparam int SUMW = W + SH;

  logic [W-1:0]    hist [DEPTH];
  logic [SUMW-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      sum <= '0;
    end else if (wr) begin
      hist[0] <= din;
      for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
      sum <= sum + SUMW'(din) - SUMW'(hist[DEPTH-1]);
    end
  end

  assign q = smooth ? sum[SUMW-1:SH] : hist[0];

  // R7: the running sum only moves on a stored sample
  p_sum_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(sum));

endmodule

// File: rtl/touch_seq.sv
module touch_seq
  import tsq_pkg::*;
#(
  parameter int CLKS_PER_STATE = 16,
  parameter int FRAME_STATES   = 230,
  parameter int SAMPLE_ST      = 29,
  parameter int X_ST           = 30,
  parameter int Y_ST           = 80,
  parameter int T0_ST          = 115,
  parameter int AUX_ST         = 163,
  parameter int IDLE_FRAMES    = 1503,
  parameter int RES_W          = 10,
  parameter int AVG_DEPTH      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pen_touch,
  input  logic [1:0]       speed,
  input  logic             aux_request,
  input  logic             aux_pick,
  input  logic             smooth,
  input  logic             sleep_req,
  input  logic             grp_sel,
  input  logic             item_sel,
  input  logic             upper_byte,
  input  logic             bus_en_n,
  input  logic             adc_done,
  input  logic [RES_W-1:0] adc_data,
  output logic             drv_x,
  output logic             drv_y,
  output logic             adc_start,
  output logic [1:0]       adc_ch,
  output logic             no_touch,
  output logic             fresh_n,
  output logic             asleep,
  output logic [7:0]       dbus
);
  localparam int SW  = $clog2(FRAME_STATES);
  localparam int IW  = $clog2(IDLE_FRAMES + 1);
  localparam int NCH = 4;
  localparam int LO  = RES_W - 8;

  logic [SW-1:0] st_idx;
  logic          tick, frame_end, run;
  logic          busy, dozing;
  ch_e           cur_ch;
  logic          aux_hold, aux_arm;
  ch_e           aux_hold_ch, aux_arm_ch;
  logic [IW-1:0] idle_cnt;
  logic [SW-1:0] x_conv, y_conv;
  logic [NCH-1:0]   wr;
  logic [RES_W-1:0] chan_q [NCH];
  logic [RES_W-1:0] res;
  logic [7:0]       byte_q;

  assign run    = !sleep_req && !dozing;
  assign x_conv = SW'(X_ST) + SW'(on_states(speed));
  assign y_conv = SW'(Y_ST) + SW'(on_states(speed));

  tsq_timebase #(
    .CLKS_PER_STATE(CLKS_PER_STATE),
    .FRAME_STATES  (FRAME_STATES)
  ) u_tb (
    .clk(clk), .rst(rst), .run(run),
    .st_idx(st_idx), .tick(tick), .frame_end(frame_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_x <= 1'b0; drv_y <= 1'b0; adc_start <= 1'b0; busy <= 1'b0;
      cur_ch <= CH_A0; no_touch <= 1'b1; fresh_n <= 1'b1; dozing <= 1'b0;
      aux_hold <= 1'b0; aux_arm <= 1'b0;
      aux_hold_ch <= CH_A0; aux_arm_ch <= CH_A0; idle_cnt <= '0;
    end else begin
      adc_start <= 1'b0;
      fresh_n   <= 1'b1;
      // request latch: cut off at the T0 state-cycle boundary
      if (aux_request) begin
        aux_hold    <= 1'b1;
        aux_hold_ch <= aux_pick ? CH_A1 : CH_A0;
      end else if (tick && st_idx == SW'(T0_ST)) begin
        aux_hold <= 1'b0;
      end
      if (tick && st_idx == SW'(T0_ST)) begin
        aux_arm    <= aux_hold;
        aux_arm_ch <= aux_hold_ch;
      end
      if (sleep_req) begin
        drv_x <= 1'b0; drv_y <= 1'b0; busy <= 1'b0; dozing <= 1'b0;
        idle_cnt <= '0; aux_hold <= 1'b0; aux_arm <= 1'b0;
      end else if (dozing) begin
        if (pen_touch || aux_request) begin
          dozing   <= 1'b0;
          idle_cnt <= '0;
        end
      end else begin
        if (tick && st_idx == SW'(SAMPLE_ST)) begin
          no_touch <= !pen_touch;
          if (pen_touch) idle_cnt <= '0;
        end
        if (tick && st_idx == SW'(X_ST) && !no_touch) drv_x <= 1'b1;
        if (tick && st_idx == SW'(Y_ST) && !no_touch) drv_y <= 1'b1;
        if (tick && st_idx == x_conv && drv_x) begin
          adc_start <= 1'b1; cur_ch <= CH_X; busy <= 1'b1;
        end
        if (tick && st_idx == y_conv && drv_y) begin
          adc_start <= 1'b1; cur_ch <= CH_Y; busy <= 1'b1;
        end
        if (tick && st_idx == SW'(AUX_ST) && aux_arm) begin
          adc_start <= 1'b1; cur_ch <= aux_arm_ch; busy <= 1'b1;
          aux_arm <= 1'b0;
        end
        if (adc_done && busy) begin
          busy  <= 1'b0;
          drv_x <= 1'b0;
          drv_y <= 1'b0;
          if (cur_ch != CH_X) fresh_n <= 1'b0;
        end
        if (frame_end && no_touch) begin
          if (idle_cnt == IW'(IDLE_FRAMES - 1)) begin
            dozing   <= 1'b1;
            idle_cnt <= '0;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign adc_ch = cur_ch;
  assign asleep = sleep_req || dozing;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign wr[c] = adc_done && busy && (cur_ch == 2'(c));
    tsq_chan_avg #(.W(RES_W), .DEPTH(AVG_DEPTH)) u_avg (
      .clk(clk), .rst(rst), .wr(wr[c]), .smooth(smooth),
      .din(adc_data), .q(chan_q[c])
    );
  end

  // channel index equals {grp_sel,item_sel}
  assign res = chan_q[{grp_sel, item_sel}];

  always_ff @(posedge clk) begin
    if (rst) byte_q <= '0;
    else if (upper_byte) byte_q <= res[RES_W-1:LO];
    else byte_q <= {res[LO-1:0], {(8-LO){1'b0}}};
  end

  assign dbus = bus_en_n ? 'z : byte_q;

  // R3: one plate at a time
  p_one_plate_r3: assert property (@(posedge clk) disable iff (rst)
    !(drv_x && drv_y));
  // R5: a plate is only energised after a pen was seen
  p_touch_gate_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_x) |-> !no_touch);
  // R6: the new-result strobe is a single clock
  p_fresh_short_r6: assert property (@(posedge clk) disable iff (rst)
    !fresh_n |=> fresh_n);
  // R2: a start request lasts one clock
  p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);
  // R10: hold-down silences the panel and the converter
  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    sleep_req |=> (!drv_x && !drv_y && !adc_start));
  // R11: nothing starts while dozing
  p_doze_idle_r11: assert property (@(posedge clk) disable iff (rst)
    dozing |-> !adc_start);

endmodule

// File: tb/touch_seq_test.sv
module touch_seq_test;
  localparam int FRAME_CLKS = 230 * 16;
  localparam int IDLE_N     = 6;
  // {pen, speed[1:0], x[9:0], y[9:0]}
  localparam logic [22:0] VEC [0:5] = '{
    {1'b1, 2'd0, 10'd100,  10'd200},
    {1'b1, 2'd1, 10'd300,  10'd400},
    {1'b0, 2'd2, 10'd555,  10'd666},
    {1'b1, 2'd2, 10'd1023, 10'd0},
    {1'b1, 2'd3, 10'd512,  10'd3},
    {1'b0, 2'd0, 10'd7,    10'd7}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic pen_touch = 1'b0, aux_request = 1'b0, aux_pick = 1'b0, smooth = 1'b0;
  logic sleep_req = 1'b0, grp_sel = 1'b0, item_sel = 1'b0, upper_byte = 1'b1;
  logic bus_en_n = 1'b1, adc_done = 1'b0;
  logic [1:0] speed = 2'd0;
  logic [9:0] adc_data = '0;
  logic drv_x, drv_y, adc_start, no_touch, fresh_n, asleep;
  logic [1:0] adc_ch;
  wire  [7:0] dbus;

  logic [9:0] vx = '0, vy = '0, va0 = '0, va1 = '0;
  int tests = 0, fails = 0, ph = 0;
  int cyc = 0, x_rise = 0, x_rise_prev = 0, y_rise = 0, on_meas = 0;
  int starts = 0, fresh_cnt = 0, dly = 0;
  logic px = 1'b0, py = 1'b0, done_flag = 1'b0;

  touch_seq #(.IDLE_FRAMES(IDLE_N)) uut (
    .clk(clk), .rst(rst), .pen_touch(pen_touch), .speed(speed),
    .aux_request(aux_request), .aux_pick(aux_pick), .smooth(smooth),
    .sleep_req(sleep_req), .grp_sel(grp_sel), .item_sel(item_sel),
    .upper_byte(upper_byte), .bus_en_n(bus_en_n), .adc_done(adc_done),
    .adc_data(adc_data), .drv_x(drv_x), .drv_y(drv_y), .adc_start(adc_start),
    .adc_ch(adc_ch), .no_touch(no_touch), .fresh_n(fresh_n), .asleep(asleep),
    .dbus(dbus)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ph <= 0;
    else ph <= (ph == FRAME_CLKS - 1) ? 0 : ph + 1;
  end

  // monitor and converter model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    adc_done = 1'b0;
    if (drv_x && !px) begin x_rise_prev = x_rise; x_rise = cyc; end
    if (drv_y && !py) y_rise = cyc;
    if (adc_start && drv_x) on_meas = cyc - x_rise;
    if (!fresh_n) fresh_cnt++;
    if (adc_start) begin
      starts++;
      dly = 3;
    end else if (dly > 0) begin
      dly--;
      if (dly == 0) begin
        adc_done = 1'b1;
        case (adc_ch)
          2'd0: adc_data = va0;
          2'd1: adc_data = va1;
          2'd2: adc_data = vx;
          default: adc_data = vy;
        endcase
      end
    end
    px = drv_x;
    py = drv_y;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic goto_pos(input int p);
    @(negedge clk);
    while (ph != p) @(negedge clk);
  endtask

  task automatic read_ch(input int ch, output int val);
    logic [7:0] hi, lo;
    grp_sel = ch[1]; item_sel = ch[0]; bus_en_n = 1'b0; upper_byte = 1'b1;
    repeat (2) @(negedge clk);
    hi = dbus;
    upper_byte = 1'b0;
    repeat (2) @(negedge clk);
    lo = dbus;
    bus_en_n = 1'b1;
    check("R9 low byte zero fill", int'(lo[5:0]), 0);
    val = {hi, lo[7:6]};
  endtask

  task automatic pulse_aux(input logic pick);
    aux_pick = pick; aux_request = 1'b1;
    @(negedge clk);
    aux_request = 1'b0;
  endtask

  function automatic int on_exp(input logic [1:0] code);
    case (code)
      2'd0: return 5 * 16;
      2'd1: return 7 * 16;
      2'd2: return 10 * 16;
      default: return 13 * 16;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [22:0] v;
    int val, f0, s0, ex, ey;
    int hx [4];
    int hy [4];
    ex = 0; ey = 0;
    for (int k = 0; k < 4; k++) begin hx[k] = 0; hy[k] = 0; end

    repeat (5) @(negedge clk);
    // R12 reset state
    check("R12 no_touch", int'(no_touch), 1);
    check("R12 fresh_n", int'(fresh_n), 1);
    check("R12 drives", int'(drv_x | drv_y | adc_start), 0);
    check("R8 bus floats", int'(dbus === 8'hzz), 1);
    rst = 1'b0;

    goto_pos(2000);
    read_ch(2, val); check("R12 X after reset", val, 0);
    read_ch(0, val); check("R12 aux0 after reset", val, 0);

    // vector table walk, one frame per row, raw mode
    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      goto_pos(3600);
      pen_touch = v[22]; speed = v[21:20]; vx = v[19:10]; vy = v[9:0];
      f0 = fresh_cnt;
      goto_pos(3000);
      check("R5 no_touch", int'(no_touch), int'(!v[22]));
      if (v[22]) begin
        ex = int'(vx); ey = int'(vy);
        for (int k = 3; k > 0; k--) begin hx[k] = hx[k-1]; hy[k] = hy[k-1]; end
        hx[0] = ex; hy[0] = ey;
        check("R2 drive on-time", on_meas, on_exp(v[21:20]));
        check("R3 X to Y spacing", y_rise - x_rise, 800);
        if (i == 1) check("R1 frame period", x_rise - x_rise_prev, FRAME_CLKS);
      end
      check("R6 fresh pulses", fresh_cnt - f0, v[22] ? 1 : 0);
      read_ch(2, val); check("R8 X channel", val, ex);
      read_ch(3, val); check("R8 Y channel", val, ey);
    end

    // R7 rolling mean, then back to raw
    smooth = 1'b1;
    read_ch(2, val); check("R7 X mean", val, (hx[0] + hx[1] + hx[2] + hx[3]) / 4);
    read_ch(3, val); check("R7 Y mean", val, (hy[0] + hy[1] + hy[2] + hy[3]) / 4);
    smooth = 1'b0;
    read_ch(2, val); check("R7 X raw", val, ex);

    // R4 request before T0, no pen present
    va1 = 10'd777;
    goto_pos(100);
    f0 = fresh_cnt;
    pulse_aux(1'b1);
    goto_pos(3000);
    read_ch(1, val); check("R4 early aux1 served", val, 777);
    read_ch(0, val); check("R4 aux0 untouched", val, 0);
    check("R6 aux fresh pulse", fresh_cnt - f0, 1);

    // R4 request after T0 waits one frame
    va0 = 10'd321;
    goto_pos(2200);
    pulse_aux(1'b0);
    goto_pos(3000);
    read_ch(0, val); check("R4 late aux0 deferred", val, 0);
    goto_pos(3000);
    read_ch(0, val); check("R4 late aux0 served", val, 321);

    // R11 idle count: one pen frame, then IDLE_N pen-free frames
    goto_pos(3600); pen_touch = 1'b1;
    goto_pos(600);  pen_touch = 1'b0;
    for (int k = 0; k < IDLE_N + 1; k++) goto_pos(3000);
    check("R11 awake before limit", int'(asleep), 0);
    repeat (1000) @(negedge clk);
    check("R11 asleep at limit", int'(asleep), 1);
    s0 = starts;
    repeat (4000) @(negedge clk);
    check("R11 no starts asleep", starts - s0, 0);

    // R11 wake by aux request, which is then served
    va1 = 10'd444;
    pulse_aux(1'b1);
    check("R11 aux wake", int'(asleep), 0);
    repeat (3000) @(negedge clk);
    read_ch(1, val); check("R11 aux after wake", val, 444);

    // R11 wake by pen
    for (int k = 0; k < 40000 && !asleep; k++) @(negedge clk);
    check("R11 asleep again", int'(asleep), 1);
    pen_touch = 1'b1;
    @(negedge clk);
    check("R11 pen wake", int'(asleep), 0);

    // R10 hold-down
    repeat (100) @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    check("R10 asleep held", int'(asleep), 1);
    s0 = starts;
    repeat (5000) @(negedge clk);
    check("R10 no starts held", starts - s0, 0);
    check("R10 no drive held", int'(drv_x | drv_y), 0);
    vx = 10'd600;
    sleep_req = 1'b0;
    repeat (FRAME_CLKS) @(negedge clk);
    check("R10 resumed pen seen", int'(no_touch), 0);
    read_ch(2, val); check("R10 X after release", val, 600);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule